// File: doc/BRIEF.md
# Configurable Asynchronous Serial Transceiver

This block is a full-duplex asynchronous serial transmitter and receiver. Three mode inputs choose the character format while the block runs. The first chooses between 7 and 8 data bits. The second adds or omits a parity bit. The third chooses one or two stop bits. Together they give eight frame shapes, from 9 to 12 bit periods long. A fourth input picks even or odd parity. The transmitter samples the format when it accepts a byte. The receiver samples it when it detects a start bit. A format change therefore never corrupts a character that is already on the line.

Both directions time their bits from a 16x oversampling tick. The tick comes from one of two sources. The first is an internal divider that fires once every `baud_div` system clocks. The second is an external clock pin, which is synchronized and edge-detected into the system clock domain. When the internal divider is in use, the 16x clock can be driven out on a pin for other devices. The parallel side has two ports. The write port takes a byte with a valid/ready handshake. The read port holds the last received character together with its error flags until software acknowledges it.

Top module: `sxc_xcvr`

## Requirements
- R1: The line idles at 1. A transmitted frame is one start bit of 0, followed by the data bits sent least significant bit first. There are 8 data bits when `cfg_char7`=0 and 7 data bits (bits 6..0) when `cfg_char7`=1.
- R2: When `cfg_par_en`=1, a parity bit follows the last data bit. Its value makes the number of ones in the data bits plus the parity bit even when `cfg_par_odd`=0, and odd when `cfg_par_odd`=1. When `cfg_par_en`=0, no parity bit is sent.
- R3: After the data and parity bits come one stop bit of 1 (`cfg_stop2`=0) or two (`cfg_stop2`=1). `tx_ready` stays low until the last stop bit has ended. Whenever `tx_ready` is high, `txd` is 1.
- R4: A byte is accepted on a clock edge where `tx_valid` and `tx_ready` are both high, and `txd` goes to 0 in the following cycle. While a frame is in progress, `tx_ready` is low. During that time, writes and changes to the format inputs do not alter the frame.
- R5: Every bit period lasts 16 oversampling ticks. With the internal source (`cfg_ext_clk`=0), a tick occurs once every `baud_div` system clocks. If `baud_div` is below 2, a tick occurs on every clock.
- R6: With `cfg_ext_clk`=1, each rising edge of `sck_in` gives exactly one single-cycle tick, after a two-flop synchronizer. One bit period therefore equals 16 periods of `sck_in`.
- R7: `sck_oe` is 1 only when `cfg_clk_out_en`=1 and `cfg_ext_clk`=0. While `sck_oe` is 1, `sck_out` is a square wave with a period of `baud_div` system clocks. While `sck_oe` is 0, `sck_out` is 0.
- R8: The receiver starts on a falling edge of `rxd` and checks the start bit again on the 8th tick after that edge. If the line is back at 1 by then, the edge is treated as noise and discarded. Otherwise each later bit is sampled at its midpoint. In 7-bit mode, `rx_data[7]` reads 0.
- R9: When parity is enabled, `rx_par_err` is set with the character if the received parity bit does not match the parity computed under R2 from the received data.
- R10: `rx_frm_err` is set with the character if the first stop bit is sampled as 0. When two stop bits are configured, the second stop bit is not checked.
- R11: A completed character sets `rx_valid` and updates `rx_data`, `rx_par_err` and `rx_frm_err`. `rx_valid` stays high until `rx_read` is pulsed, and it is low in the cycle after that pulse. A new character that arrives before the read replaces the held one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_char7 | input | 1 | 1 selects 7 data bits, 0 selects 8 |
| cfg_par_en | input | 1 | 1 inserts a parity bit |
| cfg_par_odd | input | 1 | 1 selects odd parity, 0 even |
| cfg_stop2 | input | 1 | 1 selects two stop bits |
| cfg_ext_clk | input | 1 | 1 takes the 16x tick from `sck_in` |
| cfg_clk_out_en | input | 1 | Enables driving the internal 16x clock on `sck_out` |
| baud_div | input | DIV_W | System clocks per 16x tick, internal source |
| sck_in | input | 1 | External 16x clock |
| sck_out | output | 1 | Internal 16x clock output |
| sck_oe | output | 1 | Output enable for `sck_out` |
| tx_data | input | 8 | Byte to transmit |
| tx_valid | input | 1 | Transmit request |
| tx_ready | output | 1 | Transmitter idle, can accept a byte |
| txd | output | 1 | Serial output |
| rxd | input | 1 | Serial input |
| rx_read | input | 1 | Acknowledge pulse for the held character |
| rx_data | output | 8 | Last received character |
| rx_valid | output | 1 | A character is held |
| rx_par_err | output | 1 | Parity mismatch on held character |
| rx_frm_err | output | 1 | First stop bit was 0 on held character |

## Verification
A wrong tick or sub-bit counter stretches or shortens bit periods. Mid-bit samples of `txd` then drift into the neighbouring bit within a few bits of the frame. An error in the bit counter or in the choice of phase adds, drops or moves the parity and stop bits. This shows at once at a fixed sample position of `txd`, or in the received byte and its flags one frame later. A receiver that gets stuck in an internal state misses the next character entirely, so `rx_valid` stays low. A fault in the synchronizer or the edge detector changes how many ticks one `sck_in` period produces, so the timing of an external-clock frame is off by a factor.

// File: rtl/sxc_pkg.sv
package sxc_pkg;

    typedef struct packed {
        logic char7;
        logic par_en;
        logic stop2;
        logic par_odd;
    } frame_cfg_t;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_START,
        PH_DATA,
        PH_PAR,
        PH_STOP,
        PH_STOP2
    } phase_e;

    // index of the last data bit for the selected length
    function automatic logic [2:0] last_bit(frame_cfg_t c);
        return c.char7 ? 3'd6 : 3'd7;
    endfunction

    // parity bit that completes the selected sense over the active data bits
    function automatic logic parity_of(logic [7:0] d, frame_cfg_t c);
        logic [7:0] m;
        m = c.char7 ? {1'b0, d[6:0]} : d;
        return (^m) ^ c.par_odd;
    endfunction

endpackage

// File: rtl/sxc_tick_gen.sv
module sxc_tick_gen #(
    parameter int DIV_W       = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ext_sel,
    input  logic             out_en,
    input  logic [DIV_W-1:0] div,
    input  logic             sck_in,
    output logic             tick,
    output logic             sck_out,
    output logic             sck_oe
);

    localparam int TOP = SYNC_STAGES - 1;

    typedef struct packed {
        logic [DIV_W-1:0]       cnt;
        logic [SYNC_STAGES-1:0] sync;
        logic                   prev;
        logic                   tick;
        logic                   ck;
    } tg_state_t;

    tg_state_t q, d;

    always_comb begin
        d      = q;
        d.tick = 1'b0;
        d.sync = {q.sync[TOP-1:0], sck_in};
        d.prev = q.sync[TOP];
        if (ext_sel) begin
            d.cnt  = '0;
            d.ck   = 1'b0;
            d.tick = q.sync[TOP] & ~q.prev;
        end else begin
            if (div < DIV_W'(2) || q.cnt >= div - 1'b1) begin
                d.cnt  = '0;
                d.tick = 1'b1;
            end else begin
                d.cnt = q.cnt + 1'b1;
            end
            d.ck = (d.cnt >= (div >> 1));
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign tick    = q.tick;
    assign sck_oe  = out_en & ~ext_sel;
    assign sck_out = q.ck & sck_oe;

    // R6: an external edge yields one tick, never two in a row
    a_r6_tick_single: assert property (@(posedge clk) disable iff (!rst_n)
        (ext_sel && $past(ext_sel) && tick) |=> !tick);

endmodule

// File: rtl/sxc_tx.sv
module sxc_tx
    import sxc_pkg::*;
#(
    parameter int OVS = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  frame_cfg_t cfg,
    input  logic [7:0] data,
    input  logic       valid,
    output logic       ready,
    output logic       txd
);

    localparam int CNT_W = $clog2(OVS);
    localparam logic [CNT_W-1:0] LAST_TICK = CNT_W'(OVS - 1);

    typedef struct packed {
        phase_e     phase;
        frame_cfg_t cfg;
        logic [7:0] sh;
        logic       par;
        logic [2:0] bitn;
        logic [CNT_W-1:0] tcnt;
        logic       txd;
    } tx_state_t;

    tx_state_t q, d;

    always_comb begin
        d = q;
        if (q.phase == PH_IDLE) begin
            d.txd = 1'b1;
            if (valid) begin
                d.cfg   = cfg;
                d.sh    = data;
                d.par   = parity_of(data, cfg);
                d.phase = PH_START;
                d.tcnt  = '0;
                d.txd   = 1'b0;
            end
        end else if (tick) begin
            if (q.tcnt != LAST_TICK) begin
                d.tcnt = q.tcnt + 1'b1;
            end else begin
                d.tcnt = '0;
                case (q.phase)
                    PH_START: begin
                        d.phase = PH_DATA;
                        d.bitn  = '0;
                        d.txd   = q.sh[0];
                    end
                    PH_DATA: begin
                        if (q.bitn == last_bit(q.cfg)) begin
                            if (q.cfg.par_en) begin
                                d.phase = PH_PAR;
                                d.txd   = q.par;
                            end else begin
                                d.phase = PH_STOP;
                                d.txd   = 1'b1;
                            end
                        end else begin
                            d.bitn = q.bitn + 1'b1;
                            d.sh   = q.sh >> 1;
                            d.txd  = q.sh[1];
                        end
                    end
                    PH_PAR: begin
                        d.phase = PH_STOP;
                        d.txd   = 1'b1;
                    end
                    PH_STOP: begin
                        d.phase = q.cfg.stop2 ? PH_STOP2 : PH_IDLE;
                        d.txd   = 1'b1;
                    end
                    default: begin
                        d.phase = PH_IDLE;
                        d.txd   = 1'b1;
                    end
                endcase
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q       <= '0;
            q.phase <= PH_IDLE;
            q.txd   <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign ready = (q.phase == PH_IDLE);
    assign txd   = q.txd;

    // R4: an accepted byte drives the start bit in the next cycle and blocks writes
    a_r4_start_follows: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && ready) |=> (!txd && !ready));

    // R3: the line rests high whenever the transmitter is free
    a_r3_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
        ready |-> txd);

endmodule

// File: rtl/sxc_rx.sv
module sxc_rx
    import sxc_pkg::*;
#(
    parameter int OVS = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  frame_cfg_t cfg,
    input  logic       rxd,
    input  logic       rd,
    output logic [7:0] data,
    output logic       valid,
    output logic       par_err,
    output logic       frm_err
);

    localparam int CNT_W = $clog2(OVS);
    localparam logic [CNT_W-1:0] LAST_TICK = CNT_W'(OVS - 1);
    localparam logic [CNT_W-1:0] MID_TICK  = CNT_W'(OVS / 2 - 1);

    typedef struct packed {
        logic [1:0] sync;
        logic       prev;
        phase_e     phase;
        frame_cfg_t cfg;
        logic [7:0] sh;
        logic [2:0] bitn;
        logic [CNT_W-1:0] tcnt;
        logic       par_bit;
        logic [7:0] data;
        logic       valid;
        logic       perr;
        logic       ferr;
    } rx_state_t;

    rx_state_t q, d;
    logic       line;
    logic [7:0] word;

    assign line = q.sync[1];
    assign word = q.cfg.char7 ? {1'b0, q.sh[7:1]} : q.sh;

    always_comb begin
        d      = q;
        d.sync = {q.sync[0], rxd};
        d.prev = q.sync[1];
        if (rd) begin
            d.valid = 1'b0;
        end
        case (q.phase)
            PH_IDLE: begin
                if (!line && q.prev) begin
                    d.phase = PH_START;
                    d.tcnt  = '0;
                    d.cfg   = cfg;
                end
            end
            PH_START: begin
                if (tick) begin
                    if (q.tcnt == MID_TICK) begin
                        d.tcnt  = '0;
                        d.bitn  = '0;
                        d.phase = line ? PH_IDLE : PH_DATA;
                    end else begin
                        d.tcnt = q.tcnt + 1'b1;
                    end
                end
            end
            default: begin
                if (tick) begin
                    if (q.tcnt != LAST_TICK) begin
                        d.tcnt = q.tcnt + 1'b1;
                    end else begin
                        d.tcnt = '0;
                        case (q.phase)
                            PH_DATA: begin
                                d.sh = {line, q.sh[7:1]};
                                if (q.bitn == last_bit(q.cfg)) begin
                                    d.phase = q.cfg.par_en ? PH_PAR : PH_STOP;
                                end else begin
                                    d.bitn = q.bitn + 1'b1;
                                end
                            end
                            PH_PAR: begin
                                d.par_bit = line;
                                d.phase   = PH_STOP;
                            end
                            PH_STOP: begin
                                d.data  = word;
                                d.valid = 1'b1;
                                d.ferr  = ~line;
                                d.perr  = q.cfg.par_en &&
                                          (q.par_bit != parity_of(word, q.cfg));
                                d.phase = q.cfg.stop2 ? PH_STOP2 : PH_IDLE;
                            end
                            default: begin
                                d.phase = PH_IDLE;
                            end
                        endcase
                    end
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q       <= '0;
            q.sync  <= 2'b11;
            q.prev  <= 1'b1;
            q.phase <= PH_IDLE;
        end else begin
            q <= d;
        end
    end

    assign data    = q.data;
    assign valid   = q.valid;
    assign par_err = q.perr;
    assign frm_err = q.ferr;

    // R11: an acknowledge with no character completing clears the flag
    a_r11_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && valid && q.phase != PH_STOP) |=> !valid);

    // R11: the held character only changes together with a valid flag
    a_r11_data_with_valid: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(data) |-> valid);

endmodule

// File: rtl/sxc_xcvr.sv
module sxc_xcvr
    import sxc_pkg::*;
#(
    parameter int DIV_W = 16,
    parameter int OVS   = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_char7,
    input  logic             cfg_par_en,
    input  logic             cfg_par_odd,
    input  logic             cfg_stop2,
    input  logic             cfg_ext_clk,
    input  logic             cfg_clk_out_en,
    input  logic [DIV_W-1:0] baud_div,
    input  logic             sck_in,
    output logic             sck_out,
    output logic             sck_oe,
    input  logic [7:0]       tx_data,
    input  logic             tx_valid,
    output logic             tx_ready,
    output logic             txd,
    input  logic             rxd,
    input  logic             rx_read,
    output logic [7:0]       rx_data,
    output logic             rx_valid,
    output logic             rx_par_err,
    output logic             rx_frm_err
);

    frame_cfg_t fmt;
    logic       tick;

    always_comb begin
        fmt.char7   = cfg_char7;
        fmt.par_en  = cfg_par_en;
        fmt.stop2   = cfg_stop2;
        fmt.par_odd = cfg_par_odd;
    end

    sxc_tick_gen #(.DIV_W(DIV_W), .SYNC_STAGES(2)) u_tick (
        .clk     (clk),
        .rst_n   (rst_n),
        .ext_sel (cfg_ext_clk),
        .out_en  (cfg_clk_out_en),
        .div     (baud_div),
        .sck_in  (sck_in),
        .tick    (tick),
        .sck_out (sck_out),
        .sck_oe  (sck_oe)
    );

    sxc_tx #(.OVS(OVS)) u_tx (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick),
        .cfg   (fmt),
        .data  (tx_data),
        .valid (tx_valid),
        .ready (tx_ready),
        .txd   (txd)
    );

    sxc_rx #(.OVS(OVS)) u_rx (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (tick),
        .cfg     (fmt),
        .rxd     (rxd),
        .rd      (rx_read),
        .data    (rx_data),
        .valid   (rx_valid),
        .par_err (rx_par_err),
        .frm_err (rx_frm_err)
    );

endmodule

// File: tb/sxc_xcvr_tb.sv
`timescale 1ns/1ps
module sxc_xcvr_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_char7 = 1'b0, cfg_par_en = 1'b0, cfg_par_odd = 1'b0, cfg_stop2 = 1'b0;
    logic        cfg_ext_clk = 1'b0, cfg_clk_out_en = 1'b0;
    logic [15:0] baud_div = 16'd4;
    logic        sck_in = 1'b0;
    logic        sck_out, sck_oe;
    logic [7:0]  tx_data = 8'h00;
    logic        tx_valid = 1'b0;
    logic        tx_ready, txd;
    logic        rxd = 1'b1;
    logic        rx_read = 1'b0;
    logic [7:0]  rx_data;
    logic        rx_valid, rx_par_err, rx_frm_err;
    logic        ext_run = 1'b0;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    sxc_xcvr dut_i (
        .clk(clk), .rst_n(rst_n),
        .cfg_char7(cfg_char7), .cfg_par_en(cfg_par_en), .cfg_par_odd(cfg_par_odd),
        .cfg_stop2(cfg_stop2), .cfg_ext_clk(cfg_ext_clk), .cfg_clk_out_en(cfg_clk_out_en),
        .baud_div(baud_div), .sck_in(sck_in), .sck_out(sck_out), .sck_oe(sck_oe),
        .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready), .txd(txd),
        .rxd(rxd), .rx_read(rx_read), .rx_data(rx_data), .rx_valid(rx_valid),
        .rx_par_err(rx_par_err), .rx_frm_err(rx_frm_err)
    );

    // external 16x clock: period of 8 system clocks when running
    initial begin
        forever begin
            repeat (4) @(negedge clk);
            sck_in = ext_run ? ~sck_in : 1'b0;
        end
    end

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic set_fmt(input bit c7, input bit pe, input bit s2, input bit odd);
        cfg_char7 = c7; cfg_par_en = pe; cfg_stop2 = s2; cfg_par_odd = odd;
    endtask

    function automatic bit par_calc(input logic [7:0] v, input bit c7, input bit odd);
        int ones = 0;
        for (int i = 0; i < (c7 ? 7 : 8); i++) ones += v[i];
        return bit'(ones % 2) ^ odd;
    endfunction

    // R1 R2 R3 R4: send one byte and check every bit at its midpoint
    task automatic tx_frame(input logic [7:0] v, input bit c7, input bit pe, input bit s2,
                            input bit odd, input int bc, input bit poke, input string req);
        bit exp_bits[12];
        int n = 0;
        set_fmt(c7, pe, s2, odd);
        exp_bits[n++] = 1'b0;
        for (int i = 0; i < (c7 ? 7 : 8); i++) exp_bits[n++] = v[i];
        if (pe) exp_bits[n++] = par_calc(v, c7, odd);
        exp_bits[n++] = 1'b1;
        if (s2) exp_bits[n++] = 1'b1;
        while (!tx_ready) @(negedge clk);
        tx_data = v; tx_valid = 1'b1;
        @(negedge clk);
        tx_valid = 1'b0;
        chk("R4", "txd low after accept", txd, 0);
        chk("R4", "tx_ready low when busy", tx_ready, 0);
        cyc(bc / 2);
        for (int k = 0; k < n; k++) begin
            if (k > 0) begin
                if (poke && k == 2) begin
                    tx_data = ~v; tx_valid = 1'b1;
                    cfg_char7 = ~c7; cfg_par_en = ~pe; cfg_stop2 = ~s2;
                    cyc(bc / 2);
                    tx_valid = 1'b0; set_fmt(c7, pe, s2, odd);
                    cyc(bc - bc / 2);
                end else begin
                    cyc(bc);
                end
            end
            chk(req, $sformatf("txd bit %0d", k), txd, exp_bits[k]);
        end
        chk("R3", "tx_ready low during last stop", tx_ready, 0);
        cyc(bc / 2 + 12);
        chk("R3", "tx_ready back after frame", tx_ready, 1);
        chk("R3", "line idle high", txd, 1);
    endtask

    task automatic rx_drive(input logic [7:0] v, input bit c7, input bit pe, input bit s2,
                            input bit odd, input int bc, input bit bad_par,
                            input bit stop1, input bit stop2v);
        set_fmt(c7, pe, s2, odd);
        rxd = 1'b0; cyc(bc);
        for (int i = 0; i < (c7 ? 7 : 8); i++) begin
            rxd = v[i]; cyc(bc);
        end
        if (pe) begin
            rxd = par_calc(v, c7, odd) ^ bad_par; cyc(bc);
        end
        rxd = stop1; cyc(bc);
        if (s2) begin
            rxd = stop2v; cyc(bc);
        end
        rxd = 1'b1; cyc(bc);
    endtask

    task automatic rx_check(input logic [7:0] exp_d, input bit exp_p, input bit exp_f,
                            input string req);
        chk(req, "rx_valid set", rx_valid, 1);
        chk(req, "rx_data", rx_data, exp_d);
        chk(req, "rx_par_err", rx_par_err, exp_p);
        chk(req, "rx_frm_err", rx_frm_err, exp_f);
        rx_read = 1'b1; @(negedge clk); rx_read = 1'b0;
        chk("R11", "rx_valid cleared by read", rx_valid, 0);
    endtask

    task automatic t_reset;
        cyc(3);
        chk("R3", "reset txd", txd, 1);
        chk("R3", "reset tx_ready", tx_ready, 1);
        chk("R11", "reset rx_valid", rx_valid, 0);
        chk("R7", "reset sck_oe", sck_oe, 0);
    endtask

    task automatic t_clock_out;
        int rises = 0;
        logic prev;
        baud_div = 16'd4; cfg_ext_clk = 1'b0; cfg_clk_out_en = 1'b1;
        cyc(4);
        chk("R7", "sck_oe internal", sck_oe, 1);
        prev = sck_out;
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            if (sck_out && !prev) rises++;
            prev = sck_out;
        end
        chk("R7", "sck_out rising edges in 40 clocks", rises, 10);
        cfg_ext_clk = 1'b1; cyc(3);
        chk("R7", "sck_oe off with external clock", sck_oe, 0);
        chk("R7", "sck_out low with external clock", sck_out, 0);
        cfg_ext_clk = 1'b0; cfg_clk_out_en = 1'b0; cyc(3);
        chk("R7", "sck_oe off when disabled", sck_oe, 0);
    endtask

    task automatic t_glitch;
        rxd = 1'b0; cyc(6); rxd = 1'b1;
        cyc(200);
        chk("R8", "short low pulse rejected", rx_valid, 0);
    endtask

    task automatic t_overwrite;
        rx_drive(8'h11, 0, 0, 0, 0, 64, 0, 1, 1);
        rx_drive(8'hE7, 0, 0, 0, 0, 64, 0, 1, 1);
        rx_check(8'hE7, 0, 0, "R11");
    endtask

    initial begin
        cyc(5);
        rst_n = 1'b1;
        t_reset();
        // transmit formats at 64 clocks per bit (R5: 16 ticks of 4 clocks)
        tx_frame(8'hA5, 0, 0, 0, 0, 64, 0, "R1");
        tx_frame(8'hC3, 1, 0, 0, 0, 64, 0, "R1");
        tx_frame(8'h3B, 0, 1, 0, 0, 64, 0, "R2");
        tx_frame(8'h3B, 0, 1, 1, 1, 64, 0, "R2");
        tx_frame(8'hF0, 1, 1, 1, 1, 64, 0, "R3");
        tx_frame(8'h5A, 0, 0, 1, 0, 64, 1, "R4");
        // receive formats
        rx_drive(8'h96, 0, 0, 0, 0, 64, 0, 1, 1);
        rx_check(8'h96, 0, 0, "R8");
        rx_drive(8'hD5, 1, 0, 0, 0, 64, 0, 1, 1);
        rx_check(8'h55, 0, 0, "R8");
        rx_drive(8'h6C, 0, 1, 0, 1, 64, 0, 1, 1);
        rx_check(8'h6C, 0, 0, "R9");
        rx_drive(8'h6C, 0, 1, 0, 0, 64, 1, 1, 1);
        rx_check(8'h6C, 1, 0, "R9");
        rx_drive(8'h2A, 1, 1, 1, 1, 64, 1, 1, 1);
        rx_check(8'h2A, 1, 0, "R9");
        rx_drive(8'h81, 0, 0, 0, 0, 64, 0, 0, 1);
        rx_check(8'h81, 0, 1, "R10");
        rx_drive(8'h42, 0, 0, 1, 0, 64, 0, 1, 0);
        rx_check(8'h42, 0, 0, "R10");
        t_glitch();
        t_overwrite();
        t_clock_out();
        // external clock: 8 clocks per tick, 128 clocks per bit
        cfg_ext_clk = 1'b1; ext_run = 1'b1;
        cyc(20);
        tx_frame(8'h9C, 0, 1, 0, 0, 128, 0, "R6");
        rx_drive(8'h37, 0, 0, 0, 0, 128, 0, 1, 1);
        rx_check(8'h37, 0, 0, "R6");
        ext_run = 1'b0; cfg_ext_clk = 1'b0;
        // R5: divider below 2 ticks every clock, 16 clocks per bit
        baud_div = 16'd1;
        cyc(4);
        tx_frame(8'h1E, 0, 0, 0, 0, 16, 0, "R5");
        baud_div = 16'd4;
        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog (all requirements) actual hung expected finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule